// File: doc/BRIEF.md
# Real-Time-Clock Alarm Comparator and Interrupt Flag Unit

This block sits beside the time-of-day counters of a real-time clock. It holds three alarm bytes (seconds, minutes, hours) and compares them with the current time whenever the counter logic reports that an update has just finished. It also owns the interrupt status byte, which carries three sticky flags: alarm match, update finished, and periodic. A set of enable inputs decides which of those flags raise the interrupt request line.

The periodic flag comes from a tick counter clocked by a 32.768 kHz enable pulse. A 4-bit rate code selects a power-of-two period. Software reads the status byte through a plain read strobe, and that read clears the flags. The counter arithmetic that produces the time bytes lives elsewhere. This block only samples those bytes in the cycle the update strobe is high.

Top module: `rtc_alarm_irq`

## Requirements
- R1: A write with select 0, 1 or 2 loads the seconds, minutes or hours alarm byte. A read with the same select returns that byte. All alarm bytes are 0x00 after reset. A write with select 3 changes nothing.
- R2: An alarm byte whose bits 7 and 6 are both 1 matches every value of its time field.
- R3: In a cycle where the update strobe is high, the alarm flag is set if all three alarm bytes match the time bytes presented in that same cycle. The flag is visible from the next cycle.
- R4: The hours comparison uses all 8 bits, including the PM bit 7. Hour 0x82 therefore does not match an hour alarm of 0x02.
- R5: Every cycle with the update strobe high sets the update flag.
- R6: A read with select 3 returns the status byte with this layout: bit 7 is the summary, bit 6 the periodic flag, bit 5 the alarm flag, bit 4 the update flag, and bits 3..0 are zero. The summary bit is the OR of each flag ANDed with its enable. The irq output equals the summary bit.
- R7: A status read returns the flags and clears them. A second read right after it returns 0x00.
- R8: The tick counter starts at 0 on reset and advances on each tick-enable pulse. With a rate code c in 1..15, the periodic flag is set on every tick that brings the count to a multiple of 2^(c-1). Code 13 gives 8 Hz and code 15 gives 2 Hz at 32.768 kHz.
- R9: The tick counter runs independently of the rate code. After a code change, the next periodic flag comes at the next multiple of the new period.
- R10: Rate code 0 never sets the periodic flag.
- R11: If a flag is set in the same cycle as a status read, the read returns the value from before that cycle and the new flag remains set for the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | 32.768 kHz tick enable pulse |
| upd_done | input | 1 | Time update finished this cycle |
| cur_sec | input | 8 | Current seconds byte |
| cur_min | input | 8 | Current minutes byte |
| cur_hour | input | 8 | Current hours byte, PM in bit 7 |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write select (0 sec, 1 min, 2 hour alarm) |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Register read strobe |
| rd_sel | input | 2 | Read select (0..2 alarms, 3 status) |
| rd_data | output | 8 | Read data, valid while rd_en is high |
| rate_code | input | 4 | Periodic rate selector |
| alm_ie | input | 1 | Alarm flag interrupt enable |
| upd_ie | input | 1 | Update flag interrupt enable |
| per_ie | input | 1 | Periodic flag interrupt enable |
| irq | output | 1 | Interrupt request |

## Verification
A corrupted alarm byte or a faulty comparator shows up at the first update strobe. The status read in the following cycle then has a wrong bit 5, and irq is wrong at once when the alarm enable is set. A tick counter that is off by even one count moves the periodic flag by one tick. The bench therefore reads the status one tick before and one tick after each predicted boundary, so such an error is visible within a single tick. A lost clear or a lost same-cycle set appears on the very next status read.

// File: rtl/rtc_alarm_pkg.sv
package rtc_alarm_pkg;

    localparam int BYTE_W  = 8;
    localparam int ALARM_N = 3;

    typedef enum logic [1:0] {
        SEL_SEC_ALM  = 2'd0,
        SEL_MIN_ALM  = 2'd1,
        SEL_HOUR_ALM = 2'd2,
        SEL_STATUS   = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic pf;
        logic af;
        logic uf;
    } irq_flags_t;

    // Wildcard when both upper bits are set; otherwise an exact byte compare.
    function automatic logic alarm_field_hit(input logic [BYTE_W-1:0] alm,
                                             input logic [BYTE_W-1:0] cur);
        return (alm[BYTE_W-1:BYTE_W-2] == 2'b11) || (alm == cur);
    endfunction

    function automatic logic [BYTE_W-1:0] pack_status(input irq_flags_t f,
                                                      input logic irqf);
        return {irqf, f.pf, f.af, f.uf, 4'b0000};
    endfunction

endpackage

// File: rtl/rtc_alm_match.sv
module rtc_alm_match
    import rtc_alarm_pkg::*;
#(
    parameter int FIELDS = ALARM_N,
    parameter int W      = BYTE_W
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         wr_en,
    input  logic [$clog2(FIELDS)-1:0]    wr_idx,
    input  logic [W-1:0]                 wr_data,
    input  logic [FIELDS-1:0][W-1:0]     cur_time,
    output logic [FIELDS-1:0][W-1:0]     alm_regs,
    output logic                         all_hit
);
    localparam int IDX_W = $clog2(FIELDS);

    logic [FIELDS-1:0] hit;

    for (genvar g = 0; g < FIELDS; g++) begin : g_field
        logic [W-1:0] alm_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                alm_q <= '0;
            end else if (wr_en && (wr_idx == IDX_W'(g))) begin
                alm_q <= wr_data;
            end
        end

        assign alm_regs[g] = alm_q;
        assign hit[g]      = alarm_field_hit(alm_q, cur_time[g]);
    end

    assign all_hit = &hit;

endmodule

// File: rtl/rtc_alm_rate.sv
module rtc_alm_rate #(
    parameter int RATE_W = 4,
    parameter int DIV_W  = 15
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_en,
    input  logic [RATE_W-1:0] rate_code,
    output logic              pf_evt
);
    logic [DIV_W-1:0] cnt_q;
    logic [DIV_W-1:0] cnt_nxt;
    logic [DIV_W-1:0] mask;

    assign cnt_nxt = cnt_q + DIV_W'(1);

    // Bit i belongs to the period mask when i < code-1.
    for (genvar i = 0; i < DIV_W; i++) begin : g_mask
        assign mask[i] = (32'(rate_code) > (i + 1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (tick_en) begin
            cnt_q <= cnt_nxt;
        end
    end

    assign pf_evt = tick_en && (rate_code != '0) && ((cnt_nxt & mask) == '0);

endmodule

// File: rtl/rtc_alm_flags.sv
module rtc_alm_flags
    import rtc_alarm_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  irq_flags_t set_evt,
    input  logic       rd_clr,
    input  irq_flags_t en,
    output irq_flags_t flags_q,
    output logic       irqf
);
    irq_flags_t kept;

    always_comb begin
        kept = rd_clr ? '0 : flags_q;
    end

    // A set arriving with the clearing read survives it.
    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q <= '0;
        end else begin
            flags_q <= kept | set_evt;
        end
    end

    assign irqf = |(flags_q & en);

endmodule

// File: rtl/rtc_alarm_irq.sv
module rtc_alarm_irq
    import rtc_alarm_pkg::*;
#(
    parameter int RATE_W = 4,
    parameter int DIV_W  = 15
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_en,
    input  logic              upd_done,
    input  logic [7:0]        cur_sec,
    input  logic [7:0]        cur_min,
    input  logic [7:0]        cur_hour,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [7:0]        wr_data,
    input  logic              rd_en,
    input  logic [1:0]        rd_sel,
    output logic [7:0]        rd_data,
    input  logic [RATE_W-1:0] rate_code,
    input  logic              alm_ie,
    input  logic              upd_ie,
    input  logic              per_ie,
    output logic              irq
);
    logic [ALARM_N-1:0][BYTE_W-1:0] alm_regs;
    logic                           alarm_hit;
    logic                           pf_evt;
    logic                           rd_clr;
    logic                           alm_wr;
    irq_flags_t                     set_evt;
    irq_flags_t                     en;
    irq_flags_t                     flags_q;
    logic                           irqf;

    assign alm_wr = wr_en && (reg_sel_e'(wr_sel) != SEL_STATUS);
    assign rd_clr = rd_en && (reg_sel_e'(rd_sel) == SEL_STATUS);

    rtc_alm_match #(.FIELDS(ALARM_N), .W(BYTE_W)) match_i (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (alm_wr),
        .wr_idx   (wr_sel),
        .wr_data  (wr_data),
        .cur_time ({cur_hour, cur_min, cur_sec}),
        .alm_regs (alm_regs),
        .all_hit  (alarm_hit)
    );

    rtc_alm_rate #(.RATE_W(RATE_W), .DIV_W(DIV_W)) rate_i (
        .clk       (clk),
        .rst       (rst),
        .tick_en   (tick_en),
        .rate_code (rate_code),
        .pf_evt    (pf_evt)
    );

    always_comb begin
        set_evt.pf = pf_evt;
        set_evt.af = upd_done && alarm_hit;
        set_evt.uf = upd_done;
        en.pf      = per_ie;
        en.af      = alm_ie;
        en.uf      = upd_ie;
    end

    rtc_alm_flags flags_i (
        .clk     (clk),
        .rst     (rst),
        .set_evt (set_evt),
        .rd_clr  (rd_clr),
        .en      (en),
        .flags_q (flags_q),
        .irqf    (irqf)
    );

    always_comb begin
        case (reg_sel_e'(rd_sel))
            SEL_SEC_ALM:  rd_data = alm_regs[0];
            SEL_MIN_ALM:  rd_data = alm_regs[1];
            SEL_HOUR_ALM: rd_data = alm_regs[2];
            default:      rd_data = pack_status(flags_q, irqf);
        endcase
    end

    assign irq = irqf;

endmodule

// File: rtl/rtc_alarm_irq_chk.sv
module rtc_alarm_irq_chk
    import rtc_alarm_pkg::*;
#(
    parameter int RATE_W = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              upd_done,
    input logic              alarm_hit,
    input logic              pf_evt,
    input logic              rd_clr,
    input irq_flags_t        flags,
    input logic [RATE_W-1:0] rate_code,
    input logic              alm_ie,
    input logic              upd_ie,
    input logic              per_ie,
    input logic              irq
);
    p_af_on_hit_r3: assert property (@(posedge clk) disable iff (rst)
        (upd_done && alarm_hit) |=> flags.af);

    p_af_needs_update_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(flags.af) |-> $past(upd_done && alarm_hit));

    p_uf_needs_update_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(flags.uf) |-> $past(upd_done));

    p_read_clears_r7: assert property (@(posedge clk) disable iff (rst)
        (rd_clr && !upd_done && !pf_evt) |=> (flags == '0));

    p_set_beats_clear_r11: assert property (@(posedge clk) disable iff (rst)
        (rd_clr && upd_done) |=> flags.uf);

    p_no_pf_at_zero_r10: assert property (@(posedge clk) disable iff (rst)
        $rose(flags.pf) |-> ($past(rate_code) != '0));

    p_irq_needs_enable_r6: assert property (@(posedge clk) disable iff (rst)
        (!alm_ie && !upd_ie && !per_ie) |-> !irq);

endmodule

bind rtc_alarm_irq rtc_alarm_irq_chk #(.RATE_W(RATE_W)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .upd_done  (upd_done),
    .alarm_hit (alarm_hit),
    .pf_evt    (pf_evt),
    .rd_clr    (rd_clr),
    .flags     (flags_q),
    .rate_code (rate_code),
    .alm_ie    (alm_ie),
    .upd_ie    (upd_ie),
    .per_ie    (per_ie),
    .irq       (irq)
);

// File: tb/rtc_alarm_irq_tb_top.sv
module rtc_alarm_irq_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 200000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_en = 1'b0;
    logic       upd_done = 1'b0;
    logic [7:0] cur_sec = '0, cur_min = '0, cur_hour = '0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_sel = '0;
    logic [7:0] wr_data = '0;
    logic       rd_en = 1'b0;
    logic [1:0] rd_sel = '0;
    logic [7:0] rd_data;
    logic [3:0] rate_code = '0;
    logic       alm_ie = 1'b0, upd_ie = 1'b0, per_ie = 1'b0;
    logic       irq;

    int  n_total = 0;
    int  n_bad   = 0;
    bit  done    = 1'b0;
    int  tick_cnt = 0;

    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    rtc_alarm_irq dut_i (
        .clk(clk), .rst(rst), .tick_en(tick_en), .upd_done(upd_done),
        .cur_sec(cur_sec), .cur_min(cur_min), .cur_hour(cur_hour),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .rd_en(rd_en), .rd_sel(rd_sel), .rd_data(rd_data),
        .rate_code(rate_code), .alm_ie(alm_ie), .upd_ie(upd_ie),
        .per_ie(per_ie), .irq(irq)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_total++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  test done: total=%0d bad=%0d", n_total, n_bad);
            $finish;
        end
    endtask

    // Monitor: compares read data against the scoreboard queue.
    always @(negedge clk) begin
        if (rd_en && !rst) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "scoreboard empty", rd_data, 0);
            end else begin
                logic [7:0] e;
                string      t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(rd_data === e, t, rd_data, e);
            end
        end
    end

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [1:0] sel, input logic [7:0] d);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        step();
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] sel, input logic [7:0] e, input string tag);
        exp_q.push_back(e); tag_q.push_back(tag);
        rd_en = 1'b1; rd_sel = sel;
        step();
        rd_en = 1'b0;
    endtask

    task automatic upd(input logic [7:0] h, input logic [7:0] m, input logic [7:0] s);
        cur_hour = h; cur_min = m; cur_sec = s; upd_done = 1'b1;
        step();
        upd_done = 1'b0;
    endtask

    task automatic rd_with_upd(input logic [7:0] e, input string tag);
        exp_q.push_back(e); tag_q.push_back(tag);
        rd_en = 1'b1; rd_sel = 2'd3; upd_done = 1'b1;
        step();
        rd_en = 1'b0; upd_done = 1'b0;
    endtask

    task automatic chk_irq(input logic e, input string tag);
        @(negedge clk);
        check(irq === e, tag, irq, e);
        step();
    endtask

    // Ticks separated by one idle cycle each.
    task automatic ticks(input int n);
        for (int k = 0; k < n; k++) begin
            tick_en = 1'b1;
            step();
            tick_en = 1'b0;
            step();
        end
        tick_cnt += n;
    endtask

    task automatic per_check(input logic [3:0] code, input string tag);
        int period;
        int rem;
        rate_code = code;
        period = 1 << (code - 1);
        rem = period - (tick_cnt % period);
        if (rem > 1) ticks(rem - 1);
        rd(2'd3, 8'h00, {tag, " before boundary"});
        ticks(1);
        rd(2'd3, 8'h40, {tag, " at boundary"});
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        check(1'b0, "watchdog", 0, 1);
        finish_run();
    end

    initial begin
        repeat (3) step();
        rst = 1'b0;
        step();

        // Reset state
        rd(2'd3, 8'h00, "R6 status after reset");
        rd(2'd0, 8'h00, "R1 sec alarm after reset");
        chk_irq(1'b0, "R6 irq after reset");

        // Alarm registers
        wr(2'd0, 8'h30);
        wr(2'd1, 8'hC0);
        wr(2'd2, 8'h82);
        wr(2'd3, 8'hFF);
        rd(2'd0, 8'h30, "R1 sec alarm readback");
        rd(2'd1, 8'hC0, "R1 min alarm readback");
        rd(2'd2, 8'h82, "R1 hour alarm readback");
        rd(2'd3, 8'h00, "R1 status write ignored");

        // Hour mismatch: only the update flag
        upd(8'h01, 8'h59, 8'h30);
        rd(2'd3, 8'h10, "R5 update flag only");
        rd(2'd3, 8'h00, "R7 second read is zero");

        // Full match with alarm interrupt enabled
        alm_ie = 1'b1;
        upd(8'h82, 8'h00, 8'h30);
        chk_irq(1'b1, "R6 irq on alarm");
        rd(2'd3, 8'hB0, "R3 alarm plus update with summary");
        chk_irq(1'b0, "R7 irq drops after read");

        // PM bit must match
        wr(2'd2, 8'h02);
        upd(8'h82, 8'h00, 8'h30);
        chk_irq(1'b0, "R4 no irq on AM/PM mismatch");
        rd(2'd3, 8'h10, "R4 AM alarm vs PM hour");

        // Wildcards
        wr(2'd0, 8'hC0);
        wr(2'd2, 8'hFF);
        upd(8'h15, 8'h42, 8'h07);
        rd(2'd3, 8'hB0, "R2 wildcard match");

        // Same-cycle set and read
        rd_with_upd(8'h00, "R11 read during update returns old");
        rd(2'd3, 8'hB0, "R11 flag kept for next read");

        // Update interrupt
        alm_ie = 1'b0;
        upd_ie = 1'b1;
        upd(8'h00, 8'h00, 8'h00);
        chk_irq(1'b1, "R6 irq on update flag");
        rd(2'd3, 8'hB0, "R6 summary from update flag");
        upd_ie = 1'b0;

        // Periodic flag, period 4 ticks
        rate_code = 4'd3;
        ticks(3);
        rd(2'd3, 8'h00, "R8 code 3 before fourth tick");
        ticks(1);
        rd(2'd3, 8'h40, "R8 code 3 at fourth tick");
        per_ie = 1'b1;
        ticks(4);
        chk_irq(1'b1, "R6 irq on periodic flag");
        rd(2'd3, 8'hC0, "R8 periodic with summary");
        per_ie = 1'b0;
        ticks(2);
        rd(2'd3, 8'h00, "R8 off-boundary ticks");

        // Rate change mid-period
        per_check(4'd4, "R9 code 4 after change");

        // Code 0 disables
        rate_code = 4'd0;
        ticks(20);
        rd(2'd3, 8'h00, "R10 code 0 no periodic flag");

        // Real rates
        per_check(4'd13, "R8 code 13");
        per_check(4'd15, "R8 code 15");

        step();
        finish_run();
    end

endmodule